// File: doc/BRIEF.md
# Dual-Line Edge-Triggered Interrupt Bank

This block collects up to 32 interrupt sources (24 by default) and turns selected signal edges into pending events. Each source carries a two-bit edge-select field, shared by both host lines, that picks rising edges, falling edges, both or neither. Every input passes through a two-flop synchroniser before the edge detector, so asynchronous sources can be wired in directly.

A detected edge sets the pending bit for that source in two independent status registers, one per host line, in the same cycle. Each line has its own mask register and its own active-low interrupt output. It also has an active-high summary bit that a primary aggregator can collect, one bit per bank and per line, to chain banks.

Software reaches all state through a byte-wide register port. A control register chooses how status is cleared: on read, or by writing ones. It can also buffer a second event that arrives while a bit is already pending.

Top module: `irq_bank_dual`

## Requirements
- R1: The edge-select block occupies byte addresses 0x00 to 0x07. Source i lives in byte i/4. Bit (i mod 4)*2+1 enables rising edges and bit (i mod 4)*2 enables falling edges. The fields read back as written.
- R2: A source with only the rising bit set flags 0-to-1 transitions and ignores 1-to-0 transitions. With only the falling bit set it does the reverse. With both bits set it flags either transition.
- R3: A source whose two edge bits are both 0 never sets status on either line. All edge fields reset to 0.
- R4: A detected edge sets the source's status bit on line 0 and on line 1 in the same cycle.
- R5: A mask bit of 1 stops that source from driving the line. Masks reset to all ones. irq_n[l] is low exactly when line l has a status bit set whose mask bit is 0.
- R6: With control bit 0 (clear-on-read) set, a read of a status byte clears the bits of that byte on that line only, and writes to status bytes have no effect.
- R7: With control bit 0 clear, writing a 1 to a status bit clears it, writing a 0 leaves it, and reads do not clear.
- R8: With control bit 1 set, an edge on a source that is already pending is remembered. The first clear leaves the bit set and a second clear empties it. With control bit 1 clear, one clear empties it.
- R9: Status and mask are little-endian. Line 0 status is at 0x08 to 0x0B, line 1 status at 0x0C to 0x0F, line 0 mask at 0x10 to 0x13 and line 1 mask at 0x14 to 0x17. The lowest address of each holds sources 0 to 7. The control register is at 0x18.
- R10: summary[l] is 1 exactly when line l has an unmasked pending bit. Bit 0 is line 0 and bit 1 is line 1.
- R11: An input change that is stable before a rising clock edge sets status on the third rising edge, and irq_n falls right after that edge.
- R12: When a clearing access and a new edge hit the same status bit in the same cycle, the bit remains set.
- R13: After reset, both irq_n bits are 1, summary is 0, all status and control bits read 0, and masks read 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_in | input | NSRC | Raw interrupt source levels |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (drives clear-on-read) |
| addr | input | 5 | Register byte address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for addr, combinational |
| irq_n | output | 2 | Active-low interrupt per host line |
| summary | output | 2 | Active-high pending summary per line for chaining |

## Verification
The assertions assume src_in is low while reset is applied. Otherwise a source that is already high would look like a rising edge once reset is released. They also assume wr_en and rd_en are never asserted in the same cycle. The bench holds every source at 0 through reset. Its register tasks issue one access per cycle and drop the strobe before the next access starts. Each edge it applies is held for at least four cycles, so the synchroniser sees a clean, single transition.

// File: rtl/irqb_pkg.sv
package irqb_pkg;
  localparam int ADDR_W    = 5;
  localparam logic [ADDR_W-1:0] CTRL_ADDR = 5'h18;
  localparam logic [1:0] RGN_EDGE = 2'b00;
  localparam logic [1:0] RGN_STAT = 2'b01;
  localparam logic [1:0] RGN_MASK = 2'b10;
  localparam int CTL_COR = 0;
  localparam int CTL_BUF = 1;

  // Byte of the edge block that holds source i
  function automatic int edge_byte(input int i);
    return i / 4;
  endfunction

  // Falling-edge bit of source i inside its edge byte (rising is one above)
  function automatic int edge_lsb(input int i);
    return (i % 4) * 2;
  endfunction

  // Byte of a status or mask register that holds source i
  function automatic int flag_byte(input int i);
    return i / 8;
  endfunction
endpackage

// File: rtl/irqb_edge_sense.sv
module irqb_edge_sense #(
  parameter int N = 24
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] src,
  input  logic [N-1:0] rise_en,
  input  logic [N-1:0] fall_en,
  output logic [N-1:0] hit
);
  logic [N-1:0] s1, s2, prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1   <= '0;
      s2   <= '0;
      prev <= '0;
    end else begin
      s1   <= src;
      s2   <= s1;
      prev <= s2;
    end
  end

  assign hit = (s2 & ~prev & rise_en) | (~s2 & prev & fall_en);
endmodule

// File: rtl/irqb_line.sv
module irqb_line import irqb_pkg::*; #(
  parameter int N = 24,
  localparam int NB = (N + 7) / 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  hit,
  input  logic [N-1:0]  clr,
  input  logic          buf_en,
  input  logic [NB-1:0] mask_we,
  input  logic [7:0]    mask_wd,
  output logic [N-1:0]  stat,
  output logic [N-1:0]  mask,
  output logic          pend
);
  logic [N-1:0] sec, stat_n, sec_n;

  always_comb begin
    for (int i = 0; i < N; i++) begin
      stat_n[i] = hit[i] | (stat[i] & (~clr[i] | sec[i]));
      sec_n[i]  = buf_en & ~clr[i] & ((hit[i] & stat[i]) | sec[i]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat <= '0;
      sec  <= '0;
      mask <= '1;
    end else begin
      stat <= stat_n;
      sec  <= sec_n;
      for (int i = 0; i < N; i++) begin
        if (mask_we[flag_byte(i)]) mask[i] <= mask_wd[i % 8];
      end
    end
  end

  assign pend = |(stat & ~mask);
endmodule

// File: rtl/irq_bank_dual.sv
module irq_bank_dual import irqb_pkg::*; #(
  parameter int NSRC = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   src_in,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata,
  output logic [1:0]        irq_n,
  output logic [1:0]        summary
);
  localparam int NBYTE = (NSRC + 7) / 8;

  logic [NSRC-1:0] rise_en, fall_en, en_any, hit;
  logic [1:0]      ctrl_q;
  logic            is_edge, is_stat, is_mask, is_ctrl;

  logic [NSRC-1:0]  stat_v [2];
  logic [NSRC-1:0]  mask_v [2];
  logic [NSRC-1:0]  clr_v  [2];
  logic [NBYTE-1:0] mwe_v  [2];
  logic [1:0]       pend_v;
  logic [31:0]      stat_pad [2];
  logic [31:0]      mask_pad [2];

  // Named copies for the checker
  logic [NSRC-1:0] stat_l0, stat_l1, mask_l0, mask_l1, clr_l0, clr_l1;

  assign is_edge = (addr[4:3] == RGN_EDGE);
  assign is_stat = (addr[4:3] == RGN_STAT);
  assign is_mask = (addr[4:3] == RGN_MASK);
  assign is_ctrl = (addr == CTRL_ADDR);
  assign en_any  = rise_en | fall_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rise_en <= '0;
      fall_en <= '0;
      ctrl_q  <= '0;
    end else if (wr_en) begin
      if (is_ctrl) ctrl_q <= wdata[1:0];
      for (int i = 0; i < NSRC; i++) begin
        if (is_edge && addr[2:0] == 3'(edge_byte(i))) begin
          rise_en[i] <= wdata[edge_lsb(i) + 1];
          fall_en[i] <= wdata[edge_lsb(i)];
        end
      end
    end
  end

  irqb_edge_sense #(.N(NSRC)) u_sense (
    .clk(clk), .rst_n(rst_n), .src(src_in),
    .rise_en(rise_en), .fall_en(fall_en), .hit(hit)
  );

  for (genvar l = 0; l < 2; l++) begin : g_line
    always_comb begin
      for (int i = 0; i < NSRC; i++) begin
        clr_v[l][i] = is_stat && (addr[2] == 1'(l)) &&
                      (addr[1:0] == 2'(flag_byte(i))) &&
                      (ctrl_q[CTL_COR] ? rd_en : (wr_en && wdata[i % 8]));
      end
      for (int b = 0; b < NBYTE; b++) begin
        mwe_v[l][b] = wr_en && is_mask && (addr[2] == 1'(l)) && (addr[1:0] == 2'(b));
      end
      stat_pad[l] = '0;
      mask_pad[l] = '0;
      stat_pad[l][NSRC-1:0] = stat_v[l];
      mask_pad[l][NSRC-1:0] = mask_v[l];
    end

    irqb_line #(.N(NSRC)) u_line (
      .clk(clk), .rst_n(rst_n), .hit(hit), .clr(clr_v[l]),
      .buf_en(ctrl_q[CTL_BUF]), .mask_we(mwe_v[l]), .mask_wd(wdata),
      .stat(stat_v[l]), .mask(mask_v[l]), .pend(pend_v[l])
    );

    assign irq_n[l]   = ~pend_v[l];
    assign summary[l] = pend_v[l];
  end

  assign stat_l0 = stat_v[0];
  assign stat_l1 = stat_v[1];
  assign mask_l0 = mask_v[0];
  assign mask_l1 = mask_v[1];
  assign clr_l0  = clr_v[0];
  assign clr_l1  = clr_v[1];

  always_comb begin
    rdata = '0;
    if (is_edge) begin
      for (int i = 0; i < NSRC; i++) begin
        if (addr[2:0] == 3'(edge_byte(i))) begin
          rdata[edge_lsb(i) + 1] = rise_en[i];
          rdata[edge_lsb(i)]     = fall_en[i];
        end
      end
    end else if (is_stat) begin
      rdata = stat_pad[addr[2]][{addr[1:0], 3'b000} +: 8];
    end else if (is_mask) begin
      rdata = mask_pad[addr[2]][{addr[1:0], 3'b000} +: 8];
    end else if (is_ctrl) begin
      rdata = {6'b0, ctrl_q};
    end
  end
endmodule

// File: rtl/irqb_chk.sv
module irqb_chk #(
  parameter int NSRC = 24
) (
  input logic            clk,
  input logic            rst_n,
  input logic [NSRC-1:0] hit,
  input logic [NSRC-1:0] en_any,
  input logic [NSRC-1:0] stat_l0,
  input logic [NSRC-1:0] stat_l1,
  input logic [NSRC-1:0] mask_l0,
  input logic [NSRC-1:0] mask_l1,
  input logic [NSRC-1:0] clr_l0,
  input logic [NSRC-1:0] clr_l1,
  input logic [1:0]      irq_n
);
  assert_no_set_disabled_R3: assert property (@(posedge clk) disable iff (!rst_n)
    1 |=> (((stat_l0 | stat_l1) & ~($past(stat_l0) | $past(stat_l1)) & ~$past(en_any)) == '0));

  assert_both_lines_R4: assert property (@(posedge clk) disable iff (!rst_n)
    1 |=> (($past(hit) & ~(stat_l0 & stat_l1)) == '0));

  assert_drop_needs_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    1 |=> (((~stat_l0 & $past(stat_l0) & ~$past(clr_l0)) |
            (~stat_l1 & $past(stat_l1) & ~$past(clr_l1))) == '0));

  assert_all_masked_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ((mask_l0 == '1) |-> irq_n[0]) and ((mask_l1 == '1) |-> irq_n[1]));

  assert_edge_beats_clear_R12: assert property (@(posedge clk) disable iff (!rst_n)
    1 |=> (($past(hit & clr_l0) & ~stat_l0) == '0));
endmodule

bind irq_bank_dual irqb_chk #(.NSRC(NSRC)) u_chk (
  .clk(clk), .rst_n(rst_n), .hit(hit), .en_any(en_any),
  .stat_l0(stat_l0), .stat_l1(stat_l1), .mask_l0(mask_l0), .mask_l1(mask_l1),
  .clr_l0(clr_l0), .clr_l1(clr_l1), .irq_n(irq_n)
);

// File: tb/sim_irq_bank_dual.sv
`timescale 1ns/1ps
module sim_irq_bank_dual;
  localparam int NSRC = 24;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [NSRC-1:0] src = '0;
  logic            wr_en = 1'b0, rd_en = 1'b0;
  logic [4:0]      addr = '0;
  logic [7:0]      wdata = '0;
  logic [7:0]      rdata;
  logic [1:0]      irq_n, summary;

  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  irq_bank_dual #(.NSRC(NSRC)) u0 (
    .clk(clk), .rst_n(rst_n), .src_in(src), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq_n(irq_n), .summary(summary)
  );

  // {idx[4:0], mode[1:0] (rise,fall), before, after, expect}
  localparam logic [9:0] VEC [9] = '{
    {5'd0,  2'b10, 1'b0, 1'b1, 1'b1},
    {5'd1,  2'b10, 1'b1, 1'b0, 1'b0},
    {5'd6,  2'b01, 1'b1, 1'b0, 1'b1},
    {5'd7,  2'b01, 1'b0, 1'b1, 1'b0},
    {5'd12, 2'b11, 1'b0, 1'b1, 1'b1},
    {5'd13, 2'b11, 1'b1, 1'b0, 1'b1},
    {5'd18, 2'b00, 1'b0, 1'b1, 1'b0},
    {5'd23, 2'b10, 1'b0, 1'b1, 1'b1},
    {5'd9,  2'b00, 1'b1, 1'b0, 1'b0}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a; rd_en = 1'b1;
    #1 d = rdata;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic clear_all();
    wr(5'h18, 8'h00);
    for (int b = 0; b < 3; b++) begin
      wr(5'h08 + 5'(b), 8'hFF);
      wr(5'h0C + 5'(b), 8'hFF);
    end
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    cyc(3);
    rst_n = 1'b1;
    cyc(2);

    // R13 reset state
    check(irq_n == 2'b11, "R13 irq_n", irq_n, 3);
    check(summary == 2'b00, "R13 summary", summary, 0);
    rd(5'h08, d); check(d == 8'h00, "R13 status", d, 0);
    rd(5'h14, d); check(d == 8'hFF, "R13 mask", d, 8'hFF);
    rd(5'h18, d); check(d == 8'h00, "R13 ctrl", d, 0);
    rd(5'h02, d); check(d == 8'h00, "R3 edge reset", d, 0);

    // R1 edge field readback
    wr(5'h01, 8'hB4); rd(5'h01, d); check(d == 8'hB4, "R1 edge readback", d, 8'hB4);
    wr(5'h01, 8'h00);

    // Table of edge modes: R1 R2 R3 R4
    for (int v = 0; v < 9; v++) begin
      int idx; logic [1:0] mode; logic pre, post, exp;
      logic [4:0] sa; logic [7:0] d0, d1;
      idx = int'(VEC[v][9:5]); mode = VEC[v][4:3];
      pre = VEC[v][2]; post = VEC[v][1]; exp = VEC[v][0];
      src[idx] = pre; cyc(5);
      clear_all();
      wr(5'(idx / 4), 8'(mode) << ((idx % 4) * 2));
      @(negedge clk); src[idx] = post; cyc(5);
      sa = 5'(idx / 8);
      rd(5'h08 + sa, d0); rd(5'h0C + sa, d1);
      check(d0[idx % 8] == exp, "R2 line0 edge mode", d0, 8'(exp) << (idx % 8));
      check(d1[idx % 8] == exp, "R4 line1 edge mode", d1, 8'(exp) << (idx % 8));
      wr(5'(idx / 4), 8'h00);
      src[idx] = 1'b0; cyc(5);
      clear_all();
    end

    // R11 latency and R5/R10 mask on one line only
    wr(5'h14, 8'h00);                 // line1 byte0 unmasked
    wr(5'h00, 8'h30);                 // source 2 both edges
    @(negedge clk); src[2] = 1'b1;
    @(negedge clk); @(negedge clk);
    check(irq_n == 2'b11, "R11 not yet after two edges", irq_n, 3);
    @(negedge clk);
    check(irq_n == 2'b01, "R11 set on third edge, R5 line0 masked", irq_n, 1);
    check(summary == 2'b10, "R10 summary", summary, 2);
    wr(5'h14, 8'h04);                 // mask source 2 on line1
    check(irq_n == 2'b11, "R5 mask blocks", irq_n, 3);
    wr(5'h14, 8'h00); wr(5'h10, 8'h00);
    check(irq_n == 2'b00 && summary == 2'b11, "R5 both unmasked", {summary, irq_n}, 4'b1100);
    wr(5'h10, 8'hFF); wr(5'h14, 8'hFF);
    wr(5'h00, 8'h00); src[2] = 1'b0; cyc(5); clear_all();

    // R9 little-endian: source 9 in byte 1
    wr(5'h02, 8'h08);                 // source 9 rising
    @(negedge clk); src[9] = 1'b1; cyc(5);
    rd(5'h08, d); check(d == 8'h00, "R9 low byte empty", d, 0);
    rd(5'h09, d); check(d == 8'h02, "R9 byte1 bit1", d, 2);
    wr(5'h15, 8'hFD);
    check(irq_n == 2'b01, "R9 mask byte1 unmask", irq_n, 1);
    wr(5'h15, 8'hFF);

    // R7 clear-on-write mode
    rd(5'h09, d); rd(5'h09, d); check(d == 8'h02, "R7 read keeps", d, 2);
    wr(5'h09, 8'h00); rd(5'h09, d); check(d == 8'h02, "R7 write zero keeps", d, 2);
    wr(5'h09, 8'h02); rd(5'h09, d); check(d == 8'h00, "R7 write one clears", d, 0);
    rd(5'h0D, d); check(d == 8'h02, "R7 other line kept", d, 2);

    // R6 clear-on-read mode (line1 still pending)
    wr(5'h18, 8'h01);
    wr(5'h0D, 8'hFF); rd(5'h0D, d); check(d == 8'h02, "R6 write ignored", d, 2);
    rd(5'h0D, d); check(d == 8'h00, "R6 read cleared", d, 0);
    wr(5'h02, 8'h00); src[9] = 1'b0; cyc(5); clear_all();

    // R8 buffering on
    wr(5'h01, 8'h0C);                 // source 5 both edges
    wr(5'h18, 8'h02);
    @(negedge clk); src[5] = 1'b1; cyc(5);
    src[5] = 1'b0; cyc(5);
    wr(5'h08, 8'h20); rd(5'h08, d); check(d == 8'h20, "R8 buffered survives", d, 8'h20);
    wr(5'h08, 8'h20); rd(5'h08, d); check(d == 8'h00, "R8 second clear drains", d, 0);
    // R8 buffering off
    wr(5'h18, 8'h00); clear_all();
    @(negedge clk); src[5] = 1'b1; cyc(5);
    src[5] = 1'b0; cyc(5);
    wr(5'h08, 8'h20); rd(5'h08, d); check(d == 8'h00, "R8 single clear", d, 0);
    wr(5'h01, 8'h00); clear_all();

    // R12 new edge and clear-on-read in the same cycle
    wr(5'h00, 8'hC0);                 // source 3 both edges
    wr(5'h18, 8'h01);
    @(negedge clk); src[3] = 1'b1; cyc(5);   // pending
    src[3] = 1'b0;
    @(negedge clk);                          // after first edge
    @(negedge clk);                          // after second edge: hit high now
    addr = 5'h08; rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0;
    rd(5'h08, d); check(d == 8'h08, "R12 edge wins", d, 8'h08);
    rd(5'h08, d); check(d == 8'h00, "R12 then cleared", d, 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule